// File: doc/BRIEF.md
# Spike-Timed Pattern Match Neuron Array

This block scores a query against a set of stored patterns with a row of integrate-and-fire neurons. Each neuron holds one pattern as a row of signed weights, one weight per input line. A query arrives as a series of timesteps. On each timestep a bitmask marks which input lines spike. The weights of the spiking lines are added into each neuron's current accumulator. The current, in turn, is added into a voltage accumulator. Neither accumulator leaks, so the voltage tracks a time-weighted dot product between the pattern and the query. Strong matches reach threshold first, so the order in which neurons fire ranks the matches.

The input lines come in two halves. Software writes one weight per pattern component into the positive half. The hardware supplies the negated weight for the mirror line in the negative half, so a query component of either sign produces an early spike. A neuron that reaches threshold emits a single event carrying its index and the timestep number. It is then locked out until a query clear. A query clear zeroes all neuron state and the step count, and keeps the weights and the threshold. Lines are consumed one per cycle, and events leave one per cycle on an output stream.

Top module: `mna_match_array`

## Requirements
- R1: After reset, `busy` and `ev_valid` are low. A `query_clr` pulse zeroes every current, voltage and lockout flag, and restarts the step count at 0. Weights and threshold are kept, so repeating the same query after a clear gives the same events.
- R2: During a timestep, each neuron's current grows by the sum of its weights on the lines whose bit is set in `spike_mask` (bit l is line l).
- R3: At the start of each timestep, each unlocked neuron adds the current it held before that timestep's inputs to its voltage. There is no leak on current or voltage.
- R4: A neuron whose updated voltage is greater than or equal to the signed threshold emits one event, and its voltage returns to 0. Equality fires.
- R5: Once a neuron has fired, it emits no further event and its voltage stays 0 until the next query clear.
- R6: Line h (h < HALF_LINES) uses the stored weight w[n][h]. Line h+HALF_LINES uses −w[n][h], with −128 mapped to +127 for 8-bit weights.
- R7: Events of one timestep appear on consecutive cycles in ascending neuron index. Each event's `ev_step` equals the number of strobes accepted since the last clear, counted from 0.
- R8: After a strobe is accepted, `busy` stays high for exactly 1 + F + A cycles, where F is the number of neurons firing and A is the number of set mask bits. A strobe while `busy` is high is ignored.
- R9: A strobe with an empty mask still advances the step count and still applies the voltage update.
- R10: A neuron whose voltage stays below threshold emits no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears weights, threshold and state |
| query_clr | input | 1 | Synchronous clear of neuron state and step count between queries |
| wr_en | input | 1 | Weight write strobe |
| wr_neuron | input | $clog2(NEURONS) | Neuron index of the write |
| wr_idx | input | $clog2(HALF_LINES) | Positive-half line index of the write |
| wr_weight | input | WEIGHT_W | Signed weight value |
| thr_we | input | 1 | Threshold load strobe |
| thr_in | input | VOLT_W | Signed firing threshold |
| step_go | input | 1 | Timestep strobe, accepted when not busy |
| spike_mask | input | 2*HALF_LINES | Active input lines of this timestep |
| busy | output | 1 | A timestep is in progress |
| ev_valid | output | 1 | Output event valid this cycle |
| ev_neuron | output | $clog2(NEURONS) | Index of the firing neuron |
| ev_step | output | STEP_W | Timestep number of the event |

## Verification
Results are tied to cycles after the clock edge that accepts a strobe. `busy` goes high at that edge and stays high for 1 + F + A cycles. The voltage update lands at the next edge. The first event is registered on the edge after that, and the events follow one per cycle. The current additions come next, one per active line. The bench drives the strobe at a falling edge and then samples at every following falling edge over a window longer than any step can last. It counts the `busy` cycles and compares each `ev_valid` cycle, in order, against an arithmetic model. That model applies R2 to R6 for the same weights and masks, so the order and the tag of each event, as well as the busy length, are checked on exactly the cycle they are due.

// File: rtl/mna_pkg.sv
package mna_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VOLT  = 2'd1,
        ST_EMIT  = 2'd2,
        ST_ACCUM = 2'd3
    } mna_state_e;

endpackage

// File: rtl/mna_lowest_set.sv
module mna_lowest_set #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);

    always_comb begin
        any  = |req;
        rest = req & (req - W'(1));
        idx  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mna_weight_store.sv
module mna_weight_store #(
    parameter int NEURONS    = 8,
    parameter int HALF_LINES = 6,
    parameter int WEIGHT_W   = 8,
    localparam int NIW   = $clog2(NEURONS),
    localparam int HIW   = (HALF_LINES > 1) ? $clog2(HALF_LINES) : 1,
    localparam int LINES = 2 * HALF_LINES,
    localparam int LIW   = $clog2(LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NIW-1:0]              wr_neuron,
    input  logic [HIW-1:0]              wr_idx,
    input  logic [WEIGHT_W-1:0]         wr_val,
    input  logic [LIW-1:0]              rd_line,
    output logic [NEURONS*WEIGHT_W-1:0] rd_row
);

    localparam logic [WEIGHT_W-1:0] MOST_NEG = {1'b1, {(WEIGHT_W-1){1'b0}}};

    logic [WEIGHT_W-1:0] mem_d [NEURONS][HALF_LINES];
    logic [WEIGHT_W-1:0] mem_q [NEURONS][HALF_LINES];

    logic                mirror;
    logic [LIW-1:0]      half_sel;
    logic [WEIGHT_W-1:0] raw;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_idx) < HALF_LINES) && (int'(wr_neuron) < NEURONS)) begin
            mem_d[wr_neuron][wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NEURONS; n++) begin
                for (int h = 0; h < HALF_LINES; h++) begin
                    mem_q[n][h] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Negative half of the lines reuses the positive-half storage, negated.
    always_comb begin
        mirror   = (rd_line >= LIW'(HALF_LINES));
        half_sel = mirror ? (rd_line - LIW'(HALF_LINES)) : rd_line;
        rd_row   = '0;
        raw      = '0;
        for (int n = 0; n < NEURONS; n++) begin
            raw = mem_q[n][half_sel[HIW-1:0]];
            if (!mirror) begin
                rd_row[n*WEIGHT_W +: WEIGHT_W] = raw;
            end else if (raw == MOST_NEG) begin
                rd_row[n*WEIGHT_W +: WEIGHT_W] = ~raw;
            end else begin
                rd_row[n*WEIGHT_W +: WEIGHT_W] = (~raw) + WEIGHT_W'(1);
            end
        end
    end

endmodule

// File: rtl/mna_neuron.sv
module mna_neuron #(
    parameter int WEIGHT_W = 8,
    parameter int CUR_W    = 24,
    parameter int VOLT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     volt_en_i,
    input  logic                     acc_en_i,
    input  logic [WEIGHT_W-1:0]      w_i,
    input  logic signed [VOLT_W-1:0] thr_i,
    output logic                     fire_o
);

    typedef struct packed {
        logic [CUR_W-1:0]  cur;
        logic [VOLT_W-1:0] volt;
        logic              fired;
    } nrn_t;

    nrn_t s_d, s_q;

    logic signed [VOLT_W-1:0] cur_ext_d;
    logic signed [VOLT_W-1:0] sum_d;
    logic [CUR_W-1:0]         w_ext_d;

    always_comb begin
        s_d       = s_q;
        cur_ext_d = {{(VOLT_W-CUR_W){s_q.cur[CUR_W-1]}}, s_q.cur};
        sum_d     = $signed(s_q.volt) + cur_ext_d;
        w_ext_d   = {{(CUR_W-WEIGHT_W){w_i[WEIGHT_W-1]}}, w_i};
        fire_o    = volt_en_i && !s_q.fired && (sum_d >= thr_i);
        if (clr_i) begin
            s_d = '0;
        end else begin
            if (volt_en_i && !s_q.fired) begin
                if (fire_o) begin
                    s_d.volt  = '0;
                    s_d.fired = 1'b1;
                end else begin
                    s_d.volt = sum_d;
                end
            end
            if (acc_en_i) begin
                s_d.cur = s_q.cur + w_ext_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic signed [CUR_W:0] cur_wide;
    logic signed [CUR_W:0] w_wide;
    assign cur_wide = {s_q.cur[CUR_W-1], s_q.cur};
    assign w_wide   = {{(CUR_W+1-WEIGHT_W){w_i[WEIGHT_W-1]}}, w_i};

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cur == '0 && s_q.volt == '0 && !s_q.fired));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !clr_i) |=> (cur_wide == $past(cur_wide) + $past(w_wide)));

    // R3
    volt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!volt_en_i && !clr_i) |=> $stable(s_q.volt));

    // R5
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fired && !clr_i) |=> (s_q.fired && s_q.volt == '0));

endmodule

// File: rtl/mna_match_array.sv
module mna_match_array
    import mna_pkg::*;
#(
    parameter int NEURONS    = 8,
    parameter int HALF_LINES = 6,
    parameter int WEIGHT_W   = 8,
    parameter int CUR_W      = 24,
    parameter int VOLT_W     = 32,
    parameter int STEP_W     = 8,
    localparam int NIW   = $clog2(NEURONS),
    localparam int HIW   = (HALF_LINES > 1) ? $clog2(HALF_LINES) : 1,
    localparam int LINES = 2 * HALF_LINES,
    localparam int LIW   = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  query_clr,
    input  logic                  wr_en,
    input  logic [NIW-1:0]        wr_neuron,
    input  logic [HIW-1:0]        wr_idx,
    input  logic [WEIGHT_W-1:0]   wr_weight,
    input  logic                  thr_we,
    input  logic [VOLT_W-1:0]     thr_in,
    input  logic                  step_go,
    input  logic [LINES-1:0]      spike_mask,
    output logic                  busy,
    output logic                  ev_valid,
    output logic [NIW-1:0]        ev_neuron,
    output logic [STEP_W-1:0]     ev_step
);

    typedef struct packed {
        mna_state_e         st;
        logic [LINES-1:0]   lines;
        logic [NEURONS-1:0] pend;
        logic [STEP_W-1:0]  cnt;
        logic [STEP_W-1:0]  tag;
        logic               ev_v;
        logic [NIW-1:0]     ev_n;
        logic [VOLT_W-1:0]  thr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                        volt_en_d;
    logic                        acc_en_d;
    logic [NEURONS-1:0]          fire_vec;
    logic [NEURONS*WEIGHT_W-1:0] row;

    logic               line_any;
    logic [LIW-1:0]     line_idx;
    logic [LINES-1:0]   line_rest;
    logic               emit_any;
    logic [NIW-1:0]     emit_idx;
    logic [NEURONS-1:0] emit_rest;

    mna_lowest_set #(.W(LINES)) u_line_pick (
        .req  (c_q.lines),
        .any  (line_any),
        .idx  (line_idx),
        .rest (line_rest)
    );

    mna_lowest_set #(.W(NEURONS)) u_emit_pick (
        .req  (c_q.pend),
        .any  (emit_any),
        .idx  (emit_idx),
        .rest (emit_rest)
    );

    mna_weight_store #(
        .NEURONS    (NEURONS),
        .HALF_LINES (HALF_LINES),
        .WEIGHT_W   (WEIGHT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_neuron (wr_neuron),
        .wr_idx    (wr_idx),
        .wr_val    (wr_weight),
        .rd_line   (line_idx),
        .rd_row    (row)
    );

    for (genvar g = 0; g < NEURONS; g++) begin : g_nrn
        mna_neuron #(
            .WEIGHT_W (WEIGHT_W),
            .CUR_W    (CUR_W),
            .VOLT_W   (VOLT_W)
        ) u_nrn (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (query_clr),
            .volt_en_i (volt_en_d),
            .acc_en_i  (acc_en_d),
            .w_i       (row[g*WEIGHT_W +: WEIGHT_W]),
            .thr_i     ($signed(c_q.thr)),
            .fire_o    (fire_vec[g])
        );
    end

    always_comb begin
        c_d       = c_q;
        c_d.ev_v  = 1'b0;
        volt_en_d = 1'b0;
        acc_en_d  = 1'b0;
        if (thr_we) begin
            c_d.thr = thr_in;
        end
        if (query_clr) begin
            c_d.st    = ST_IDLE;
            c_d.lines = '0;
            c_d.pend  = '0;
            c_d.cnt   = '0;
            c_d.tag   = '0;
        end else begin
            unique case (c_q.st)
                ST_IDLE: begin
                    if (step_go) begin
                        c_d.lines = spike_mask;
                        c_d.tag   = c_q.cnt;
                        c_d.cnt   = c_q.cnt + STEP_W'(1);
                        c_d.st    = ST_VOLT;
                    end
                end
                ST_VOLT: begin
                    volt_en_d = 1'b1;
                    c_d.pend  = fire_vec;
                    if (|fire_vec) begin
                        c_d.st = ST_EMIT;
                    end else if (line_any) begin
                        c_d.st = ST_ACCUM;
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                end
                ST_EMIT: begin
                    c_d.ev_v = emit_any;
                    c_d.ev_n = emit_idx;
                    c_d.pend = emit_rest;
                    if (emit_rest == '0) begin
                        c_d.st = line_any ? ST_ACCUM : ST_IDLE;
                    end
                end
                ST_ACCUM: begin
                    acc_en_d  = line_any;
                    c_d.lines = line_rest;
                    if (line_rest == '0) begin
                        c_d.st = ST_IDLE;
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy      = (c_q.st != ST_IDLE);
    assign ev_valid  = c_q.ev_v;
    assign ev_neuron = c_q.ev_n;
    assign ev_step   = c_q.tag;

    // Record of neurons already reported in this query, for the refire check.
    logic [NEURONS-1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (query_clr) begin
            seen_q <= '0;
        end else if (ev_valid) begin
            seen_q[ev_neuron] <= 1'b1;
        end
    end

    // R5
    refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !seen_q[ev_neuron]);

    // R7
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && $past(ev_valid)) |-> ((ev_neuron > $past(ev_neuron)) && (ev_step == $past(ev_step))));

    // R8
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && step_go && !query_clr) |=> busy);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !query_clr) |=> (ev_step == $past(ev_step)));

endmodule

// File: tb/mna_match_array_tb.sv
module mna_match_array_tb;

    localparam int N  = 8;
    localparam int H  = 6;
    localparam int L  = 2 * H;
    localparam int WW = 8;
    localparam int CW = 24;
    localparam int VW = 32;
    localparam int SW = 8;
    localparam int NIW = $clog2(N);
    localparam int HIW = $clog2(H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          query_clr = 1'b0;
    logic          wr_en = 1'b0;
    logic [NIW-1:0] wr_neuron = '0;
    logic [HIW-1:0] wr_idx = '0;
    logic [WW-1:0] wr_weight = '0;
    logic          thr_we = 1'b0;
    logic [VW-1:0] thr_in = '0;
    logic          step_go = 1'b0;
    logic [L-1:0]  spike_mask = '0;
    logic          busy;
    logic          ev_valid;
    logic [NIW-1:0] ev_neuron;
    logic [SW-1:0] ev_step;

    always #10 clk = ~clk;

    mna_match_array #(
        .NEURONS(N), .HALF_LINES(H), .WEIGHT_W(WW),
        .CUR_W(CW), .VOLT_W(VW), .STEP_W(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .query_clr(query_clr),
        .wr_en(wr_en), .wr_neuron(wr_neuron), .wr_idx(wr_idx), .wr_weight(wr_weight),
        .thr_we(thr_we), .thr_in(thr_in),
        .step_go(step_go), .spike_mask(spike_mask),
        .busy(busy), .ev_valid(ev_valid), .ev_neuron(ev_neuron), .ev_step(ev_step)
    );

    int total = 0;
    int bad = 0;

    int     wmem [N][H];
    longint mu [N];
    longint mv [N];
    bit     mf [N];
    int     mcnt;
    longint mthr;
    int     exp_q[$];
    int     exp_tag;
    int     obs_q[$];
    int     seen_cnt [N];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wline(input int n, input int l);
        if (l < H) return wmem[n][l];
        if (wmem[n][l-H] == -128) return 127;
        return -wmem[n][l-H];
    endfunction

    task automatic model_clear();
        for (int n = 0; n < N; n++) begin
            mu[n] = 0; mv[n] = 0; mf[n] = 0; seen_cnt[n] = 0;
        end
        mcnt = 0;
    endtask

    task automatic model_step(input logic [L-1:0] m, output int f);
        exp_q.delete();
        for (int n = 0; n < N; n++) begin
            if (!mf[n]) begin
                mv[n] += mu[n];
                if (mv[n] >= mthr) begin
                    exp_q.push_back(n);
                    mv[n] = 0;
                    mf[n] = 1;
                end
            end
        end
        for (int n = 0; n < N; n++) begin
            for (int l = 0; l < L; l++) begin
                if (m[l]) mu[n] += wline(n, l);
            end
        end
        f = exp_q.size();
        exp_tag = mcnt;
        mcnt = (mcnt + 1) % 256;
    endtask

    task automatic write_w(input int n, input int h, input int w);
        @(negedge clk);
        wr_en = 1'b1; wr_neuron = NIW'(n); wr_idx = HIW'(h); wr_weight = WW'(w);
        wmem[n][h] = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_thr(input int t);
        @(negedge clk);
        thr_we = 1'b1; thr_in = VW'(t);
        mthr = t;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        query_clr = 1'b1;
        @(negedge clk);
        query_clr = 1'b0;
        model_clear();
    endtask

    task automatic run_step(input logic [L-1:0] m, input bit poke);
        int f, a, bcnt, k, e;
        model_step(m, f);
        a = $countones(m);
        obs_q.delete();
        @(negedge clk);
        step_go = 1'b1; spike_mask = m;
        @(negedge clk);
        if (poke) begin
            step_go = 1'b1; spike_mask = '1;
        end else begin
            step_go = 1'b0;
        end
        bcnt = 0; k = 0;
        for (int c = 0; c < L + N + 8; c++) begin
            if (busy) bcnt++;
            if (ev_valid) begin
                obs_q.push_back(int'(ev_neuron));
                seen_cnt[ev_neuron]++;
                e = (k < exp_q.size()) ? exp_q[k] : -1;
                chk(int'(ev_neuron) == e, "R4 R7 event neuron order", ev_neuron, e);
                chk(int'(ev_step) == exp_tag, "R7 R9 event step tag", ev_step, exp_tag);
                k++;
            end
            @(negedge clk);
            step_go = 1'b0;
        end
        chk(bcnt == 1 + f + a, "R8 busy length", bcnt, 1 + f + a);
        chk(k == f, "R2 R3 R10 event count", k, f);
    endtask

    function automatic logic [L-1:0] qmask(input int k, input int q);
        logic [L-1:0] m = '0;
        if (k % 4 == 3) return m;
        for (int l = 0; l < L; l++) begin
            m[l] = ((l * 7 + k * 3 + q * 5) % 4 == 0);
        end
        return m;
    endfunction

    task automatic run_query(input int q, output int fired_total);
        fired_total = 0;
        for (int k = 0; k < 12; k++) begin
            run_step(qmask(k, q), (k == 5));
            fired_total += obs_q.size();
        end
        for (int n = 0; n < N; n++) begin
            chk(seen_cnt[n] <= 1, "R5 single event per neuron", seen_cnt[n], 1);
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t1, t2;
        int thr_list [3] = '{300, 1500, 6000};
        model_clear();
        mthr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(ev_valid == 1'b0, "R1 no event after reset", ev_valid, 0);

        for (int n = 0; n < N; n++) begin
            for (int h = 0; h < H; h++) begin
                write_w(n, h, ((n * 37 + h * 53 + 11) % 256) - 128);
            end
        end
        write_w(0, 0, -128);
        write_w(1, 1, 127);

        // R2 R3 R4: sweep thresholds and query patterns
        for (int ti = 0; ti < 3; ti++) begin
            for (int q = 0; q < 2; q++) begin
                set_thr(thr_list[ti]);
                do_clear();
                run_query(q, t1);
            end
        end

        // R1: clear keeps weights and threshold; the same query repeats
        set_thr(300);
        do_clear();
        run_query(0, t1);
        do_clear();
        run_query(0, t2);
        chk(t1 == t2, "R1 repeat after clear", t2, t1);

        // R6 R4: mirror of -128 gives +127, and equality fires
        set_thr(127);
        do_clear();
        run_step(L'(1) << H, 1'b0);
        run_step('0, 1'b0);
        chk(obs_q.size() == 1, "R6 R4 mirror event count", obs_q.size(), 1);
        chk(obs_q.size() > 0 && obs_q[0] == 0, "R6 R4 mirror neuron", (obs_q.size() > 0) ? obs_q[0] : -1, 0);

        // R10 R9: one above the voltage gives no event; empty steps keep integrating
        set_thr(128);
        do_clear();
        run_step(L'(1) << H, 1'b0);
        run_step('0, 1'b0);
        chk(obs_q.size() == 0, "R10 below threshold", obs_q.size(), 0);
        run_step('0, 1'b0);
        chk(obs_q.size() > 0 && obs_q[0] == 0, "R9 R5 later fire", (obs_q.size() > 0) ? obs_q[0] : -1, 0);
        run_step('0, 1'b0);
        run_step('1, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule